// File: doc/BRIEF.md
# Temperature Limit Event Generator

This block watches a stream of temperature samples and drives one active-low event line. Each new sample goes in on a valid strobe. It is compared against three signed limits: an upper and a lower bound that form an alarm window, and a separate critical threshold. The event line stands for an open-drain pin. A low level means the pin pulls down. A high level means the pin is released.

Three configuration bits set the behaviour. The first enables the output. The second picks comparator behaviour, which works like a thermostat and tracks the latest sample. The third restricts the output to the critical condition alone. In interrupt behaviour, a change of the alarm condition latches the line until software sends a clear pulse. The critical condition cannot be cleared this way.

Temperatures and limits are two's complement words, and the LSB weighs 0.25 °C. The configuration bits act on the output straight away. A sample acts on the output from the clock cycle after the edge on which its strobe is sampled.

Top module: `temp_event_gen`

## Requirements
- R1: After reset, and in every cycle where `cfg_evt_en` is 0, `evt_n` is 1 (released).
- R2: In comparator mode with the event enabled, a sample strictly greater than `lim_upper` drives `evt_n` to 0. A sample equal to `lim_upper` does not.
- R3: In comparator mode with the event enabled, a sample strictly less than `lim_lower` drives `evt_n` to 0. A sample equal to `lim_lower` does not.
- R4: In comparator mode (`cfg_int_mode`=0), `evt_n` follows the most recent sample only. A sample inside the window and below the critical limit releases the line.
- R5: While the most recent sample is greater than or equal to `lim_crit` (signed), `evt_n` is 0 whenever the event is enabled, in every mode.
- R6: With `cfg_crit_only`=1, samples outside the window but below `lim_crit` leave `evt_n` at 1.
- R7: In interrupt mode (`cfg_int_mode`=1), a sample whose alarm condition differs from that of the previous sample sets a latch, in either direction. The latch holds `evt_n` at 0 until a cycle with `int_clr`=1.
- R8: An `int_clr` pulse has no visible effect while the most recent sample is at or above `lim_crit`. The line stays at 0.
- R9: If `int_clr` and a condition-changing sample meet in the same cycle, the new event wins and the latch stays set.
- R10: A cycle with `cfg_evt_en`=0, or with `cfg_int_mode`=0, discards a pending interrupt latch. After returning to interrupt mode, the line is released until a new change.
- R11: Temperature and limit inputs have no effect in cycles without `smp_vld`. The output keeps the state set by the last strobed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | New-sample strobe |
| smp_temp | input | TW | Signed sample, 0.25 °C per LSB |
| lim_upper | input | TW | Signed upper window bound |
| lim_lower | input | TW | Signed lower window bound |
| lim_crit | input | TW | Signed critical threshold |
| cfg_evt_en | input | 1 | Output enable; 0 releases the line |
| cfg_int_mode | input | 1 | 1 selects latched interrupt behaviour, 0 comparator |
| cfg_crit_only | input | 1 | 1 restricts the alarm to the critical condition |
| int_clr | input | 1 | Clear pulse for the interrupt latch |
| evt_n | output | 1 | Active-low event, 0 means pull the pin low |

## Verification
Two functions can fall in the same cycle: a condition-changing sample that sets the interrupt latch, and a clear pulse that empties it. The bench forces this case on purpose. It strobes a window-crossing sample together with `int_clr` and expects the line to stay low afterwards. A random phase also lets clear pulses and strobes line up by chance. A second overlap is a clear pulse that arrives while the sample sits at or above the critical limit. That case is judged by the line staying low. In every cycle, the behavioural model's expected level is compared with `evt_n`.

// File: rtl/tev_pkg.sv
package tev_pkg;
   // Comparison kind of one limit checker
   typedef enum logic [1:0] {
      CMP_ABOVE = 2'd0,   // sample >  limit
      CMP_BELOW = 2'd1,   // sample <  limit
      CMP_ATLEAST = 2'd2  // sample >= limit
   } cmp_kind_e;

   localparam int NUM_LIMITS = 3;

   typedef struct packed {
      logic crit;
      logic below;
      logic above;
   } lim_flags_t;

   function automatic cmp_kind_e kind_of(input int idx);
      case (idx)
         0: return CMP_ABOVE;
         1: return CMP_BELOW;
         default: return CMP_ATLEAST;
      endcase
   endfunction
endpackage

// File: rtl/tev_cmp.sv
module tev_cmp
   import tev_pkg::*;
#(
   parameter int TW = 13,
   parameter cmp_kind_e KIND = CMP_ABOVE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [TW-1:0] smp_temp,
   input  logic signed [TW-1:0] lim,
   output logic                 flag_q,
   output logic                 flag_nx
);
   logic hit;

   generate
      if (KIND == CMP_ABOVE) begin : g_above
         assign hit = smp_temp > lim;
      end else if (KIND == CMP_BELOW) begin : g_below
         assign hit = smp_temp < lim;
      end else begin : g_atleast
         assign hit = smp_temp >= lim;
      end
   endgenerate

   assign flag_nx = smp_vld ? hit : flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_nx;
   end
endmodule

// File: rtl/tev_irq.sv
module tev_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic set_req,
   input  logic clr_req,
   output logic pend_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (!arm)    pend_q <= 1'b0;
      else if (set_req) pend_q <= 1'b1;
      else if (clr_req) pend_q <= 1'b0;
   end
endmodule

// File: rtl/temp_event_gen.sv
module temp_event_gen
   import tev_pkg::*;
#(
   parameter int TW = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [TW-1:0] smp_temp,
   input  logic signed [TW-1:0] lim_upper,
   input  logic signed [TW-1:0] lim_lower,
   input  logic signed [TW-1:0] lim_crit,
   input  logic                 cfg_evt_en,
   input  logic                 cfg_int_mode,
   input  logic                 cfg_crit_only,
   input  logic                 int_clr,
   output logic                 evt_n
);
   localparam int MIN_TW = 11;
   localparam int MAX_TW = 32;

   generate
      if (TW < MIN_TW || TW > MAX_TW) begin : g_bad_tw
         $error("temp_event_gen: TW out of range");
      end
   endgenerate

   logic signed [TW-1:0] lim_arr [NUM_LIMITS];
   logic [NUM_LIMITS-1:0] fq, fnx;
   lim_flags_t flg_q, flg_nx;

   assign lim_arr[0] = lim_upper;
   assign lim_arr[1] = lim_lower;
   assign lim_arr[2] = lim_crit;

   generate
      for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_lim
         tev_cmp #(.TW(TW), .KIND(kind_of(i))) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_vld (smp_vld),
            .smp_temp(smp_temp),
            .lim     (lim_arr[i]),
            .flag_q  (fq[i]),
            .flag_nx (fnx[i])
         );
      end
   endgenerate

   assign flg_q  = lim_flags_t'(fq);
   assign flg_nx = lim_flags_t'(fnx);

   logic alarm_cur, alarm_nxt, chg, arm, pend;

   assign alarm_cur = cfg_crit_only ? flg_q.crit
                                    : (flg_q.above | flg_q.below | flg_q.crit);
   assign alarm_nxt = cfg_crit_only ? flg_nx.crit
                                    : (flg_nx.above | flg_nx.below | flg_nx.crit);
   assign chg = smp_vld & (alarm_nxt != alarm_cur);
   assign arm = cfg_evt_en & cfg_int_mode;

   tev_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .set_req(chg),
      .clr_req(int_clr),
      .pend_q (pend)
   );

   logic evt_act;
   always_comb begin
      if (!cfg_evt_en)       evt_act = 1'b0;
      else if (cfg_int_mode) evt_act = pend | flg_q.crit;
      else                   evt_act = alarm_cur;
   end

   assign evt_n = ~evt_act;
endmodule

module temp_event_gen_chk #(
   parameter int TW = 13
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_vld,
   input logic signed [TW-1:0] smp_temp,
   input logic signed [TW-1:0] lim_upper,
   input logic signed [TW-1:0] lim_lower,
   input logic signed [TW-1:0] lim_crit,
   input logic                 cfg_evt_en,
   input logic                 cfg_int_mode,
   input logic                 cfg_crit_only,
   input logic                 int_clr,
   input logic                 evt_n
);
   a_r1_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_evt_en |-> evt_n);

   a_r5_crit_asserts: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && smp_temp >= lim_crit) |=> (!evt_n || !cfg_evt_en));

   a_r2_above_in_comparator: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && smp_temp > lim_upper && !cfg_int_mode && !cfg_crit_only)
      |=> (!evt_n || !cfg_evt_en || cfg_int_mode || cfg_crit_only));

   a_r4_inside_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !cfg_int_mode && smp_temp <= lim_upper && smp_temp >= lim_lower
       && smp_temp < lim_crit) |=> evt_n);

   a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_evt_en && cfg_int_mode && !evt_n && !int_clr && !smp_vld)
      |=> (!evt_n || !cfg_evt_en || !cfg_int_mode));
endmodule

bind temp_event_gen temp_event_gen_chk #(.TW(TW)) u_chk (.*);

// File: tb/tb_temp_event_gen.sv
module tb_temp_event_gen;
   localparam int TW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic signed [TW-1:0] smp_temp = '0;
   logic signed [TW-1:0] lim_upper = '0;
   logic signed [TW-1:0] lim_lower = '0;
   logic signed [TW-1:0] lim_crit = '0;
   logic cfg_evt_en = 1'b0;
   logic cfg_int_mode = 1'b0;
   logic cfg_crit_only = 1'b0;
   logic int_clr = 1'b0;
   logic evt_n;

   always #2 clk = ~clk;  // 250 MHz

   temp_event_gen #(.TW(TW)) dut (.*);

   // behavioural reference state
   int m_hi = 0, m_lo = 0, m_cr = 0, m_lat = 0;
   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit started = 0, done = 0;
   string cur_tag = "";

   function automatic int alarm_of(int hi, int lo, int cr, bit co);
      return co ? cr : ((hi | lo | cr) != 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hi = 0; m_lo = 0; m_cr = 0; m_lat = 0;
      end else begin
         int old_al, new_al, nh, nl, nc;
         started = 1;
         nh = m_hi; nl = m_lo; nc = m_cr;
         if (smp_vld) begin
            nh = (int'(smp_temp) > int'(lim_upper));
            nl = (int'(smp_temp) < int'(lim_lower));
            nc = (int'(smp_temp) >= int'(lim_crit));
         end
         old_al = alarm_of(m_hi, m_lo, m_cr, cfg_crit_only);
         new_al = alarm_of(nh, nl, nc, cfg_crit_only);
         if (!cfg_evt_en || !cfg_int_mode) m_lat = 0;
         else if (smp_vld && old_al != new_al) m_lat = 1;
         else if (int_clr) m_lat = 0;
         m_hi = nh; m_lo = nl; m_cr = nc;
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         int act;
         string tg;
         if (!cfg_evt_en) act = 0;
         else if (cfg_int_mode) act = (m_lat | m_cr) != 0;
         else act = alarm_of(m_hi, m_lo, m_cr, cfg_crit_only);
         tg = cur_tag;
         if (tg == "") begin
            if (!cfg_evt_en) tg = "R1";
            else if (m_cr != 0) tg = "R5";
            else if (cfg_int_mode) tg = "R7";
            else tg = "R4";
         end
         n_cmp++;
         if (evt_n !== logic'(!act)) begin
            n_bad++;
            $display("FAIL %s: evt_n actual=%b expected=%b at cycle %0d",
                     tg, evt_n, !act, cyc);
         end
      end
   end

   task automatic step(input string tag, input bit v, input int t, input bit clr);
      @(posedge clk); #1;
      cur_tag = tag; smp_vld = v; smp_temp = TW'(t); int_clr = clr;
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 1'b0, int'(smp_temp), 1'b0);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin : stim
      cur_tag = "R1";
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle("R1", 2);                         // R1 reset state
      lim_upper = 100; lim_lower = 0; lim_crit = 320;
      cfg_evt_en = 1;
      // R2 upper bound, equality excluded
      step("R2", 1, 100, 0); idle("R2", 2);
      step("R2", 1, 101, 0); idle("R2", 2);
      // R3 lower bound, equality excluded
      step("R3", 1, 0, 0);   idle("R3", 2);
      step("R3", 1, -1, 0);  idle("R3", 2);
      // R4 comparator follows latest sample
      step("R4", 1, 50, 0);  idle("R4", 2);
      // R1 disable releases
      step("R1", 1, 200, 0); cfg_evt_en = 0; idle("R1", 2); cfg_evt_en = 1; idle("R4", 1);
      // R5 / R6 critical-only
      cfg_crit_only = 1;
      step("R6", 1, 200, 0); idle("R6", 2);
      step("R6", 1, -50, 0); idle("R6", 2);
      step("R5", 1, 320, 0); idle("R5", 2);
      step("R6", 1, 319, 0); idle("R6", 2);
      cfg_crit_only = 0;
      // R7 interrupt latching, both directions
      step("R7", 1, 50, 0);  idle("R7", 1);
      cfg_int_mode = 1;      idle("R7", 2);
      step("R7", 1, 150, 0); idle("R7", 2);
      step("R7", 1, 150, 0); idle("R7", 2);
      step("R7", 0, 150, 1); idle("R7", 2);
      step("R7", 1, 50, 0);  idle("R7", 2);
      step("R7", 0, 50, 1);  idle("R7", 2);
      // R11 inputs ignored without strobe
      step("R11", 0, 500, 0); lim_upper = -100; lim_crit = -100; idle("R11", 3);
      lim_upper = 100; lim_crit = 320; idle("R11", 1);
      // R8 clear ignored at critical
      step("R8", 1, 400, 0); idle("R8", 1);
      step("R8", 0, 400, 1); idle("R8", 3);
      // R9 set wins over coincident clear
      step("R9", 1, 50, 1);  idle("R9", 3);
      step("R9", 0, 50, 1);  idle("R9", 2);
      // R10 pending latch discarded by disable
      step("R10", 1, 150, 0); idle("R10", 1);
      cfg_evt_en = 0; idle("R10", 1); cfg_evt_en = 1; idle("R10", 3);
      step("R10", 1, 50, 0);  idle("R10", 1);
      cfg_int_mode = 0; idle("R10", 1); cfg_int_mode = 1; idle("R10", 3);
      // random mixing of strobes, clears and configuration
      lim_upper = 40; lim_lower = -40; lim_crit = 80;
      for (int k = 0; k < 4000; k++) begin
         step("", ($urandom % 3) == 0, int'($urandom % 241) - 120, ($urandom % 5) == 0);
         if ($urandom % 50 == 0) cfg_int_mode = ~cfg_int_mode;
         if ($urandom % 80 == 0) cfg_crit_only = ~cfg_crit_only;
         if ($urandom % 120 == 0) cfg_evt_en = ~cfg_evt_en;
      end
      idle("", 2);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule